// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Registers

This block holds the host-visible control and status state of one channel of a bus-master disk DMA controller. Host software reaches it through a small 8-byte I/O window. The window has three registers. A command byte starts and stops the transfer engine and sets the transfer direction. A status byte reports engine activity, errors, the device interrupt and two per-drive DMA-capable flags. A 32-bit pointer gives the base of the descriptor table in memory.

The data mover sits beside the block. It receives a run level, a one-cycle start pulse, the direction and the table base. It reports end of table and bus errors back. The drive's interrupt line comes in directly and is latched into status. An interrupt output follows the latched interrupt flag. A flag output reports whether the status byte currently describes a good completion.

Each host write is one cycle with an address and data. Reads are combinational from the addressed register.

Top module: `bmdma_regs`

## Requirements
- R1: After reset every register reads zero, and `eng_run`, `eng_start`, `eng_to_mem`, `irq` and `xfer_ok` are low.
- R2: A write to offset 0 with bit 0 set, while the stored go bit is 0, makes `eng_run` and status bit 0 high from the next cycle. It also pulses `eng_start` high for exactly that one cycle. Writing bit 0 set again while the go bit is already 1 gives no new pulse.
- R3: A write to offset 0 with bit 0 clear clears the go bit and drops `eng_run` in the next cycle. Offset 0 reads back only bit 0 (go) and bit 3 (direction); all its other bits read zero.
- R4: Command bit 3 is stored on every offset-0 write and drives `eng_to_mem`. A value of 1 means the device is read and memory is written.
- R5: `eng_done` or `eng_err` while `eng_run` is high drops `eng_run` and status bit 0 in the next cycle.
- R6: `eng_err` sets status bit 1 and `dev_irq` sets status bit 2 in the next cycle. If a set event and a clearing write arrive in the same cycle, the bit ends up set.
- R7: A write to offset 2 clears status bit 1 or bit 2 where the written bit is 1. Where the written bit is 0, the status bit is unchanged.
- R8: Status bits 5 and 6 are plain read/write drive-capable flags for drive 0 and drive 1. Status bits 3, 4 and 7 read zero.
- R9: The pointer at offset 4 holds 32 bits and its bits 1:0 always read zero. A pointer write while `eng_run` is high is ignored. `eng_table` shows the stored pointer.
- R10: `irq` is high exactly while status bit 2 is set.
- R11: `xfer_ok` is high exactly when status bits 2:0 equal 100b (idle, no error, interrupt seen).
- R12: Offsets 1, 3, 5, 6 and 7 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Byte offset inside the register window |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data (byte registers use bits 7:0) |
| reg_rdata | output | 32 | Read data of the addressed register |
| eng_run | output | 1 | Engine may move data (status active bit) |
| eng_start | output | 1 | One-cycle pulse when a transfer is started |
| eng_to_mem | output | 1 | 1: device to memory, 0: memory to device |
| eng_table | output | 32 | Descriptor table base address |
| eng_done | input | 1 | Engine reached the end of the descriptor table |
| eng_err | input | 1 | Engine saw a bus error |
| dev_irq | input | 1 | Interrupt from the attached drive |
| irq | output | 1 | Interrupt request to the host |
| xfer_ok | output | 1 | Status shows a good completion |

## Verification
The bench probes the cycles where two sources act on one bit. If a clearing write landed in the same cycle as an error or device interrupt, a design that let the write win would lose an interrupt. If a start bit was written again while already set, a design that retriggered would restart the engine in the middle of a table. It checks that pointer writes during a transfer are ignored; a careless design would silently move the table under a running engine. It also checks that the capability flags survive writes that clear status bits, since a design treating the whole byte as W1C or as plain storage would lose or corrupt them. A long stretch of random traffic then compares every output against a behavioural model on every cycle.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
    // Number of drives on the channel, one capable flag each
    parameter int DRIVES = 2;

    // Register offsets inside the 8-byte window (software depends on these)
    localparam logic [2:0] OFF_CMD  = 3'd0;
    localparam logic [2:0] OFF_STAT = 3'd2;
    localparam logic [2:0] OFF_PTR  = 3'd4;

    // Command bit positions
    localparam int CMD_GO  = 0;
    localparam int CMD_DIR = 3;

    // Status bit positions
    localparam int ST_ACT = 0;
    localparam int ST_ERR = 1;
    localparam int ST_INT = 2;
    localparam int ST_CAP = 5;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic go;
        logic to_mem;
        logic active;
        logic kick;
    } ctrl_t;

    typedef struct packed {
        logic              err;
        logic              intr;
        logic [DRIVES-1:0] cap;
    } stat_t;
endpackage

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
    import bmdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic go_val,
    input  logic dir_val,
    input  logic eng_done,
    input  logic eng_err,
    output logic go,
    output logic to_mem,
    output logic active,
    output logic kick
);
    ctrl_t st_d, st_q;
    logic  start_edge;
    logic  stop_req;

    always_comb begin
        st_d       = st_q;
        st_d.kick  = 1'b0;
        start_edge = cmd_wr && go_val && !st_q.go;
        stop_req   = cmd_wr && !go_val;
        if (cmd_wr) begin
            st_d.go     = go_val;
            st_d.to_mem = dir_val;
        end
        if (start_edge) begin
            st_d.active = 1'b1;
            st_d.kick   = 1'b1;
        end else if (stop_req || eng_done || eng_err) begin
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign go     = st_q.go;
    assign to_mem = st_q.to_mem;
    assign active = st_q.active;
    assign kick   = st_q.kick;
endmodule

// File: rtl/bmdma_stat.sv
module bmdma_stat
    import bmdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_wr,
    input  logic              err_clr,
    input  logic              int_clr,
    input  logic [DRIVES-1:0] cap_val,
    input  logic              eng_err,
    input  logic              dev_irq,
    output logic              err,
    output logic              intr,
    output logic [DRIVES-1:0] cap
);
    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_wr) begin
            st_d.cap = cap_val;
            if (err_clr) st_d.err  = 1'b0;
            if (int_clr) st_d.intr = 1'b0;
        end
        // hardware events win over a same-cycle clear
        if (eng_err) st_d.err  = 1'b1;
        if (dev_irq) st_d.intr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err  = st_q.err;
    assign intr = st_q.intr;
    assign cap  = st_q.cap;
endmodule

// File: rtl/bmdma_ptr.sv
module bmdma_ptr #(
    parameter int DATA_W = 32,
    parameter int ALIGN  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_wr,
    input  logic              lock,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ptr
);
    localparam int KEEP = DATA_W - ALIGN;

    logic [KEEP-1:0] base_d, base_q;

    always_comb begin
        base_d = base_q;
        if (ptr_wr && !lock) base_d = wdata[DATA_W-1:ALIGN];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end

    assign ptr = {base_q, {ALIGN{1'b0}}};
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              eng_run,
    output logic              eng_start,
    output logic              eng_to_mem,
    output logic [DATA_W-1:0] eng_table,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic              dev_irq,
    output logic              irq,
    output logic              xfer_ok
);
    localparam int PTR_ALIGN = 2;

    logic              wr_cmd, wr_stat, wr_ptr;
    logic              go, active, err, intr;
    logic [DRIVES-1:0] cap;
    logic [BYTE_W-1:0] cmd_byte;
    logic [BYTE_W-1:0] status_byte;

    assign wr_cmd  = reg_wr && (reg_addr == ADDR_W'(OFF_CMD));
    assign wr_stat = reg_wr && (reg_addr == ADDR_W'(OFF_STAT));
    assign wr_ptr  = reg_wr && (reg_addr == ADDR_W'(OFF_PTR));

    bmdma_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (wr_cmd),
        .go_val   (reg_wdata[CMD_GO]),
        .dir_val  (reg_wdata[CMD_DIR]),
        .eng_done (eng_done),
        .eng_err  (eng_err),
        .go       (go),
        .to_mem   (eng_to_mem),
        .active   (active),
        .kick     (eng_start)
    );

    bmdma_stat u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .st_wr   (wr_stat),
        .err_clr (reg_wdata[ST_ERR]),
        .int_clr (reg_wdata[ST_INT]),
        .cap_val (reg_wdata[ST_CAP +: DRIVES]),
        .eng_err (eng_err),
        .dev_irq (dev_irq),
        .err     (err),
        .intr    (intr),
        .cap     (cap)
    );

    bmdma_ptr #(.DATA_W(DATA_W), .ALIGN(PTR_ALIGN)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ptr_wr (wr_ptr),
        .lock   (active),
        .wdata  (reg_wdata),
        .ptr    (eng_table)
    );

    always_comb begin
        cmd_byte          = '0;
        cmd_byte[CMD_GO]  = go;
        cmd_byte[CMD_DIR] = eng_to_mem;
    end

    // status byte assembly; capable flags placed by generate
    logic [BYTE_W-1:0] status_core;
    always_comb begin
        status_core         = '0;
        status_core[ST_ACT] = active;
        status_core[ST_ERR] = err;
        status_core[ST_INT] = intr;
    end

    genvar g;
    generate
        for (g = 0; g < BYTE_W; g++) begin : g_stat
            if (g >= ST_CAP && g < ST_CAP + DRIVES) begin : g_cap
                assign status_byte[g] = cap[g - ST_CAP];
            end else begin : g_core
                assign status_byte[g] = status_core[g];
            end
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFF_CMD):  reg_rdata[BYTE_W-1:0] = cmd_byte;
            ADDR_W'(OFF_STAT): reg_rdata[BYTE_W-1:0] = status_byte;
            ADDR_W'(OFF_PTR):  reg_rdata = eng_table;
            default:           reg_rdata = '0;
        endcase
    end

    assign eng_run = active;
    assign irq     = intr;
    assign xfer_ok = (status_byte[ST_INT:ST_ACT] == 3'b100);
endmodule

// File: rtl/bmdma_chk.sv
module bmdma_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              wd_int,
    input logic              eng_run,
    input logic              eng_start,
    input logic              eng_done,
    input logic              eng_err,
    input logic              dev_irq,
    input logic [DATA_W-1:0] eng_table,
    input logic [2:1]        st_flags,
    input logic              irq
);
    assert_start_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> eng_run);

    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    assert_halt_on_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_run && (eng_done || eng_err)) |=> !eng_run);

    assert_err_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_err |=> st_flags[1]);

    assert_int_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dev_irq |=> (st_flags[2] && irq));

    assert_int_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(2) && wd_int && !dev_irq) |=> !st_flags[2]);

    assert_ptr_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_run && reg_wr && reg_addr == ADDR_W'(4)) |=> $stable(eng_table));
endmodule

bind bmdma_regs bmdma_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .wd_int    (reg_wdata[2]),
    .eng_run   (eng_run),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .eng_err   (eng_err),
    .dev_irq   (dev_irq),
    .eng_table (eng_table),
    .st_flags  (status_byte[2:1]),
    .irq       (irq)
);

// File: tb/tb_bmdma_regs.sv
module tb_bmdma_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_run, eng_start, eng_to_mem, irq, xfer_ok;
    logic [31:0] eng_table;
    logic        eng_done = 1'b0, eng_err = 1'b0, dev_irq = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    bmdma_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_run(eng_run),
        .eng_start(eng_start), .eng_to_mem(eng_to_mem), .eng_table(eng_table),
        .eng_done(eng_done), .eng_err(eng_err), .dev_irq(dev_irq),
        .irq(irq), .xfer_ok(xfer_ok)
    );

    // behavioural reference state
    bit        m_go, m_dir, m_act, m_err, m_int, m_pulse;
    bit [1:0]  m_cap;
    bit [31:0] m_ptr;

    always @(posedge clk) begin
        bit start_now;
        if (!rst_n) begin
            m_go = 0; m_dir = 0; m_act = 0; m_err = 0; m_int = 0;
            m_pulse = 0; m_cap = 0; m_ptr = 0;
        end else begin
            start_now = reg_wr && reg_addr == 0 && reg_wdata[0] && !m_go;
            if (reg_wr && reg_addr == 4 && !m_act) m_ptr = reg_wdata & 32'hFFFF_FFFC;
            if (start_now) m_act = 1;
            else if ((reg_wr && reg_addr == 0 && !reg_wdata[0]) || eng_done || eng_err) m_act = 0;
            m_pulse = start_now;
            if (reg_wr && reg_addr == 0) begin
                m_go = reg_wdata[0]; m_dir = reg_wdata[3];
            end
            if (reg_wr && reg_addr == 2) begin
                m_cap = reg_wdata[6:5];
                if (reg_wdata[1]) m_err = 0;
                if (reg_wdata[2]) m_int = 0;
            end
            if (eng_err) m_err = 1;
            if (dev_irq) m_int = 1;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return {28'd0, m_dir, 2'b00, m_go};
            3'd2: return {25'd0, m_cap, 2'b00, m_int, m_err, m_act};
            3'd4: return m_ptr;
            default: return 32'd0;
        endcase
    endfunction

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string rl;
        case (reg_addr)
            3'd0: rl = "R3 cmd read";
            3'd2: rl = "R6/R7/R8 status read";
            3'd4: rl = "R9 pointer read";
            default: rl = "R12 vendor/unused read";
        endcase
        cmp(rl, reg_rdata, exp_rd(reg_addr));
        cmp("R2/R5 eng_run", {31'd0, eng_run}, {31'd0, m_act});
        cmp("R2 eng_start", {31'd0, eng_start}, {31'd0, m_pulse});
        cmp("R4 eng_to_mem", {31'd0, eng_to_mem}, {31'd0, m_dir});
        cmp("R9 eng_table", eng_table, m_ptr);
        cmp("R10 irq", {31'd0, irq}, {31'd0, m_int});
        cmp("R11 xfer_ok", {31'd0, xfer_ok}, {31'd0, !m_act && !m_err && m_int});
    endtask

    // one cycle: drive inputs, let the edge pass, compare at the falling edge
    task automatic step(input logic [2:0] a, input logic w, input logic [31:0] d,
                        input logic dn, input logic er, input logic di);
        reg_addr = a; reg_wr = w; reg_wdata = d;
        eng_done = dn; eng_err = er; dev_irq = di;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic rd(input logic [2:0] a);
        step(a, 0, 0, 0, 0, 0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        step(a, 1, d, 0, 0, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state, literal expectations
        cmp("R1 rdata cmd", reg_rdata, 32'd0);
        cmp("R1 outputs", {27'd0, eng_run, eng_start, eng_to_mem, irq, xfer_ok}, 32'd0);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) rd(3'(a));

        // R9: alignment and pointer storage
        wr(4, 32'h1234_5677); rd(4);
        cmp("R9 aligned pointer", reg_rdata, 32'h1234_5674);
        // R8: capable flags, reserved bits zero
        wr(2, 32'hFFFF_FFF8); rd(2);
        cmp("R8 cap flags only", reg_rdata, 32'h0000_0060);
        // R12: vendor offsets inert
        wr(1, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF);
        rd(0); cmp("R12 cmd untouched", reg_rdata, 32'd0);

        // R2/R4: start with direction to memory
        wr(0, 32'h0000_00FF);
        cmp("R2 start pulse", {31'd0, eng_start}, 32'd1);
        cmp("R4 direction", {31'd0, eng_to_mem}, 32'd1);
        rd(0); cmp("R3 cmd readback", reg_rdata, 32'h0000_0009);
        cmp("R2 pulse one cycle", {31'd0, eng_start}, 32'd0);
        wr(0, 32'h9); cmp("R2 no retrigger", {31'd0, eng_start}, 32'd0);
        // R9: pointer locked during run
        wr(4, 32'hAAAA_0000); rd(4);
        cmp("R9 write ignored while active", reg_rdata, 32'h1234_5674);
        // device interrupt then end of table -> good completion
        step(2, 0, 0, 0, 0, 1);
        step(2, 0, 0, 1, 0, 0);
        cmp("R5 done stops", {31'd0, eng_run}, 32'd0);
        cmp("R11 good completion", {31'd0, xfer_ok}, 32'd1);
        cmp("R10 irq high", {31'd0, irq}, 32'd1);
        // R7: zero write keeps, one write clears, caps kept
        wr(2, 32'h60); rd(2); cmp("R7 zero keeps", reg_rdata, 32'h64);
        wr(2, 32'h64); rd(2); cmp("R7 one clears", reg_rdata, 32'h60);

        // restart (go must be written 0 first), then error path
        wr(0, 32'h0); wr(0, 32'h1);
        cmp("R2 restart", {31'd0, eng_start}, 32'd1);
        step(2, 0, 0, 0, 1, 0);
        cmp("R5 error stops", {31'd0, eng_run}, 32'd0);
        rd(2); cmp("R6 error flagged", reg_rdata, 32'h62);
        // R6: set wins over same-cycle clear
        step(2, 1, 32'h66, 0, 1, 1); rd(2);
        cmp("R6 set beats clear", reg_rdata, 32'h66);
        cmp("R11 error is not good", {31'd0, xfer_ok}, 32'd0);
        // R3: stop write
        wr(0, 32'h1); wr(0, 32'h8);
        cmp("R3 stop", {31'd0, eng_run}, 32'd0);

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(3'(r[2:0]), r[3], $urandom, (r[7:4] == 0), (r[11:8] == 0), (r[15:12] == 0));
        end

        summary();
        $finish;
    end
endmodule